// File: doc/BRIEF.md
# Polyphase Non-Recursive CIC Decimator

This block is the first rate-reduction step behind a sigma-delta modulator. It takes a narrow signed sample at the oversampled rate, qualified by a valid strobe. It returns one full-precision signed word, with its own one-cycle strobe, for every 64 samples it accepts. The response is that of four cascaded 64-tap boxcar filters. It is built without feedback integrators.

The reduction by 64 is split into six cascaded halving sections. Each section applies the binomial taps 1, 4, 6, 4, 1 in two-phase polyphase form, so all of its adds happen once per output pair, at that section's own reduced rate. Constant taps become shifts and adds, and no coefficient is stored. Every section widens its word by four bits. The 4-bit input therefore grows to a 28-bit output with no rounding and no wrap. The asynchronous active-low reset is released through a two-flop synchronizer. After release, in_valid may be raised from the third rising clock edge onward.

Top module: `cicp_decim_top`

## Requirements
- R1: While reset is active, out_valid is 0 and out_data is 0. Reset also clears every stored sample and phase, so filtering after a reset starts as if all earlier inputs were zero.
- R2: out_valid is high for exactly one cycle for every 64 accepted inputs (cycles with in_valid high). It is never high in two consecutive cycles and never high at any other time.
- R3: When the k-th accepted input (k a multiple of 64) is captured at a rising edge, out_valid is high in the cycle that begins at the 5th rising edge after that one.
- R4: Number the accepted samples x[n], starting at 0 after reset, with x[n]=0 for n<0. Output number m (from 0) is the sum over j=0..252 of h[j]*x[64m+63-j], where h is four 64-long all-ones sequences convolved together.
- R5: A constant input c, held for at least 256 accepted samples, produces output words equal to c*2^24 from output 3 onward.
- R6: Cycles with in_valid low have no effect, whatever in_data carries. Gaps of any length between accepted samples leave every output value unchanged.
- R7: out_data holds its last value in every cycle where out_valid is low.
- R8: in_data is 4-bit two's complement and out_data is 28-bit two's complement. The extremes -8 and +7, held constant, give -2^27 and 7*2^24 with no wrap, and out_data never exceeds 7*2^24.
- R9: A reset applied in the middle of a stream discards the partial 64-sample frame and all history. The stream that follows is filtered exactly as it would be after a fresh reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the oversampled input rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | High when in_data carries a sample to accept |
| in_data | input | 4 | Signed modulator sample |
| out_valid | output | 1 | One-cycle strobe marking a new decimated word |
| out_data | output | 28 | Signed full-precision decimated word |

## Verification
Each section registers its result, so a decimated word lags the capture of its 64th sample by six register stages. It is visible in the sixth clock cycle after the cycle in which that sample was driven. The bench drives inputs on falling edges and tags every 64th accepted sample with that due cycle. It computes the expected word from its own boxcar-convolution model. On every falling edge, it checks either that the strobe and value appear exactly in the due cycle, or that the strobe is low and the held value is unchanged. Fixed-input and reset cases check the settled values only after the strobe has passed and the output is holding.

// File: rtl/cicp_pkg.sv
`timescale 1ns/1ps
package cicp_pkg;
  // Word growth of one halving section with taps 1,4,6,4,1 (tap sum 16).
  localparam int unsigned SEC_GROWTH = 4;
  // Sign-extension width used inside a section.
  localparam int unsigned SEC_EXT = SEC_GROWTH;
endpackage

// File: rtl/cicp_rst_sync.sv
`timescale 1ns/1ps
module cicp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cicp_half_section.sv
`timescale 1ns/1ps
// One decimate-by-2 section: y[m] = x[2m+1] + 4x[2m] + 6x[2m-1] + 4x[2m-2] + x[2m-3]
// Even branch carries taps 4,4; odd branch carries taps 1,6,1.
module cicp_half_section #(
  parameter int unsigned IW = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        in_vld,
  input  logic signed [IW-1:0]                        in_dat,
  output logic                                        out_vld,
  output logic signed [IW+cicp_pkg::SEC_GROWTH-1:0]   out_dat
);
  import cicp_pkg::*;
  localparam int unsigned OW = IW + SEC_GROWTH;

  // phase and sample history
  logic                 odd_q;
  logic signed [IW-1:0] ev0_q, ev1_q;   // x[2m], x[2m-2]
  logic signed [IW-1:0] od1_q, od2_q;   // x[2m-1], x[2m-3]

  // enables and next values
  logic                 ld_even, ld_odd;
  logic signed [OW-1:0] w_x, w_e0, w_e1, w_o1, w_o2;
  logic signed [OW-1:0] even_br, odd_br, sum_d;

  always_comb begin
    ld_even = in_vld & ~odd_q;
    ld_odd  = in_vld &  odd_q;
    w_x     = {{SEC_EXT{in_dat[IW-1]}}, in_dat};
    w_e0    = {{SEC_EXT{ev0_q[IW-1]}},  ev0_q};
    w_e1    = {{SEC_EXT{ev1_q[IW-1]}},  ev1_q};
    w_o1    = {{SEC_EXT{od1_q[IW-1]}},  od1_q};
    w_o2    = {{SEC_EXT{od2_q[IW-1]}},  od2_q};
    even_br = (w_e0 + w_e1) <<< 2;
    odd_br  = w_x + w_o2 + (w_o1 <<< 2) + (w_o1 <<< 1);
    sum_d   = even_br + odd_br;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_q   <= 1'b0;
      ev0_q   <= '0;
      ev1_q   <= '0;
      od1_q   <= '0;
      od2_q   <= '0;
      out_vld <= 1'b0;
      out_dat <= '0;
    end else begin
      out_vld <= ld_odd;
      if (in_vld) begin
        odd_q <= ~odd_q;
      end
      if (ld_even) begin
        ev1_q <= ev0_q;
        ev0_q <= in_dat;
      end
      if (ld_odd) begin
        od2_q   <= od1_q;
        od1_q   <= in_dat;
        out_dat <= sum_d;
      end
    end
  end
endmodule

// File: rtl/cicp_decim_top.sv
`timescale 1ns/1ps
module cicp_decim_top #(
  parameter  int unsigned IN_W     = 4,
  parameter  int unsigned LOG2_DEC = 6,
  localparam int unsigned OUT_W    = IN_W + cicp_pkg::SEC_GROWTH * LOG2_DEC
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  import cicp_pkg::*;

  logic rst_core_n;

  cicp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_core_n)
  );

  for (genvar gi = 0; gi < LOG2_DEC; gi++) begin : g_sec
    localparam int unsigned SIW = IN_W + SEC_GROWTH * gi;
    logic                              sv_in;
    logic signed [SIW-1:0]             sd_in;
    logic                              sv_out;
    logic signed [SIW+SEC_GROWTH-1:0]  sd_out;

    if (gi == 0) begin : g_head
      assign sv_in = in_valid;
      assign sd_in = in_data;
    end else begin : g_link
      assign sv_in = g_sec[gi-1].sv_out;
      assign sd_in = g_sec[gi-1].sd_out;
    end

    cicp_half_section #(.IW(SIW)) u_sec (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .in_vld  (sv_in),
      .in_dat  (sd_in),
      .out_vld (sv_out),
      .out_dat (sd_out)
    );
  end

  assign out_valid = g_sec[LOG2_DEC-1].sv_out;
  assign out_data  = g_sec[LOG2_DEC-1].sd_out;
endmodule

// File: rtl/cicp_decim_chk.sv
`timescale 1ns/1ps
module cicp_decim_chk #(
  parameter int unsigned IN_W     = 4,
  parameter int unsigned LOG2_DEC = 6,
  parameter int unsigned OUT_W    = 28
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_data
);
  localparam int unsigned LAST = LOG2_DEC - 2;
  localparam logic signed [OUT_W-1:0] MAXV =
    OUT_W'(((64'(1) << (IN_W-1)) - 1) << (cicp_pkg::SEC_GROWTH * LOG2_DEC));

  logic [LOG2_DEC-1:0] acc_q;
  logic [LAST:0]       due_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      due_q <= '0;
    end else begin
      if (in_valid) begin
        acc_q <= acc_q + 1'b1;
      end
      due_q <= {due_q[LAST-1:0], in_valid && (acc_q == '1)};
    end
  end

  // R1: outputs cleared while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_rst_clear_r1: assert (!out_valid && out_data == '0);
    end
  end

  // R3: strobe arrives on schedule after the 64th sample
  p_due_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    due_q[LAST] |=> out_valid);

  // R2: no strobe without a completed frame
  p_no_extra_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !due_q[LAST] |=> !out_valid);

  // R2: strobe is a single-cycle pulse
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7: word holds between strobes
  p_hold_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

  // R8: output never exceeds the largest reachable positive value
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_data <= MAXV);
endmodule

bind cicp_decim_top cicp_decim_chk #(
  .IN_W(IN_W), .LOG2_DEC(LOG2_DEC), .OUT_W(OUT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/sim_cicp_decim_top.sv
`timescale 1ns/1ps
module sim_cicp_decim_top;
  localparam int HLEN = 253;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic signed [3:0]  in_data;
  logic               out_valid;
  logic signed [27:0] out_data;

  cicp_decim_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int acc_cnt = 0;
  int last_out = 0;
  int h[HLEN];
  int hist[$];
  int exp_due[$];
  int exp_val[$];
  bit finished = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int ref_out();
    int n = hist.size() - 1;
    int s = 0;
    for (int j = 0; j < HLEN; j++) begin
      if (n - j >= 0) s += h[j] * hist[n-j];
    end
    return s;
  endfunction

  task automatic build_h();
    int a[HLEN];
    int b[HLEN];
    for (int i = 0; i < HLEN; i++) a[i] = (i < 64) ? 1 : 0;
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < HLEN; i++) begin
        b[i] = 0;
        for (int k = 0; k < 64; k++) if (i - k >= 0) b[i] += a[i-k];
      end
      a = b;
    end
    h = a;
  endtask

  // one cycle: check outputs from the last edge, then drive the next input
  task automatic step(input bit v, input int d);
    @(negedge clk);
    cyc++;
    if (exp_due.size() > 0 && exp_due[0] == cyc) begin
      chk("R2 R3 strobe due", int'(out_valid), 1);
      chk("R4 word value", int'(out_data), exp_val[0]);
      last_out = exp_val[0];
      void'(exp_due.pop_front());
      void'(exp_val.pop_front());
    end else begin
      chk("R2 R3 strobe idle", int'(out_valid), 0);
      chk("R7 word held", int'(out_data), last_out);
    end
    in_valid = v;
    in_data  = d[3:0];
    if (v) begin
      hist.push_back(d);
      acc_cnt++;
      if (acc_cnt % 64 == 0) begin
        exp_due.push_back(cyc + 6);
        exp_val.push_back(ref_out());
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    cyc++;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = 4'sd5;
    hist.delete();
    exp_due.delete();
    exp_val.delete();
    acc_cnt = 0;
    last_out = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      cyc++;
      chk("R1 strobe in reset", int'(out_valid), 0);
      chk("R1 word in reset", int'(out_data), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, $urandom_range(15) - 8);
  endtask

  task automatic run_random(input int n, input int gap_pct);
    int done = 0;
    while (done < n) begin
      if ($urandom_range(99) < gap_pct) begin
        step(1'b0, $urandom_range(15) - 8);   // R6: junk on idle cycles
      end else begin
        step(1'b1, $urandom_range(15) - 8);
        done++;
      end
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 10; i++) step(1'b0, $urandom_range(15) - 8);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    build_h();
    do_reset();

    // R4: impulse response
    step(1'b1, 1);
    for (int i = 1; i < 320; i++) step(1'b1, 0);
    flush();

    // R5 R8: constant +7
    do_reset();
    for (int i = 0; i < 320; i++) step(1'b1, 7);
    flush();
    chk("R5 R8 settled +7", int'(out_data), 7 * (1 << 24));

    // R8: constant -8 reaches the negative end
    do_reset();
    for (int i = 0; i < 320; i++) step(1'b1, -8);
    flush();
    chk("R8 settled -8", int'(out_data), -8 * (1 << 24));

    // R5: constant -3 with gaps (R6)
    do_reset();
    for (int i = 0; i < 320; i++) begin
      step(1'b1, -3);
      if (i % 3 == 0) step(1'b0, 7);
    end
    flush();
    chk("R5 R6 settled -3 with gaps", int'(out_data), -3 * (1 << 24));

    // R4 R6: random data, dense then sparse
    do_reset();
    run_random(1280, 0);
    run_random(1280, 60);
    flush();

    // R9: reset mid-frame, then repeat a known stream
    run_random(100, 20);
    do_reset();
    run_random(640, 30);
    flush();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule